// File: doc/BRIEF.md
# Predicated Partitioned SIMD ALU

This block is a 64-bit integer ALU that can run as one full-width element or be split into two, four or eight equal lanes. Each lane carries its own predicate bit. Every operand arrives as two 32-bit halves, with the high half placed above the low half. The ALU adds, subtracts, or applies a bitwise AND, OR or XOR. Carries and borrows stop at the lane boundaries set by the chosen element width.

The predicate comes from a port of eight 4-bit condition fields. One bit of each field is used. A per-instruction 2-bit selector picks that bit, or bit 0 is used when the instruction supplies no selector. The element width sets which fields feed which lanes. Byte b of the datapath takes its predicate from field b with its low bits cleared, down to the lane size. Each lane therefore reads the field at its own lowest byte. When predication is off, every lane executes.

The lane predicate is widened to a byte-enable mask. Bytes that are masked off return the old destination value instead of the ALU result. The merged result, the byte-enable mask and a valid bit are registered, so results appear one cycle after the operands.

Top module: `simd_pred_alu`

## Requirements
- R1: The 64-bit operands are {a_hi, a_lo} and {b_hi, b_lo}. In full-width mode a carry out of bit 31 propagates into bit 32.
- R2: The predicate bit taken from each condition field is bit `bit_sel` (0 to 3) when `sel_avail` is 1, and bit 0 when `sel_avail` is 0.
- R3: With `width` = 0 (64-bit), all eight bytes share one predicate, taken from field 0 (cond_fields[3:0]).
- R4: With `width` = 1 (32-bit), bytes 0 to 3 use field 0 and bytes 4 to 7 use field 4 (cond_fields[19:16]).
- R5: With `width` = 2 (16-bit), the 16-bit lane j (bytes 2j and 2j+1) uses field 2j. Odd-numbered fields are ignored.
- R6: With `width` = 3 (8-bit), byte i uses field i (cond_fields[4i+3:4i]).
- R7: When `pred_en` is 0, `byte_en` is 8'hFF whatever the condition fields hold, and every byte carries the ALU result.
- R8: A byte whose `byte_en` bit is 0 outputs the matching byte of `old_dst`.
- R9: Opcode 0 adds and opcode 1 subtracts (A + ~B + 1), both modulo the lane width. No carry or borrow crosses a lane boundary.
- R10: Opcodes 2, 3 and 4 give A AND B, A OR B and A XOR B. Opcodes 5 to 7 give zero in every enabled byte.
- R11: `out_valid`, `result` and `byte_en` appear one clock after the inputs that produced them. `out_valid` equals the previous cycle's `in_valid`, and reset clears all three to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| a_hi | input | 32 | Operand A, upper half |
| a_lo | input | 32 | Operand A, lower half |
| b_hi | input | 32 | Operand B, upper half |
| b_lo | input | 32 | Operand B, lower half |
| width | input | 2 | Element width: 0=64, 1=32, 2=16, 3=8 bits |
| op | input | 3 | 0 add, 1 sub, 2 and, 3 or, 4 xor |
| cond_fields | input | 32 | Eight 4-bit condition fields, field 0 in bits [3:0] |
| bit_sel | input | 2 | Which bit of each field is the predicate |
| sel_avail | input | 1 | 1: use bit_sel; 0: use bit 0 |
| pred_en | input | 1 | Predication enable |
| old_dst | input | 64 | Previous destination value, kept in masked bytes |
| out_valid | output | 1 | Registered valid |
| result | output | 64 | Registered merged result |
| byte_en | output | 8 | Registered byte-enable mask |

## Verification
The bench builds the block with its default parameters: 32-bit halves, eight byte lanes and 4-bit condition fields. With these values all four element widths are available, the field-to-lane mapping of every mode can be checked, and so can the carry cut at the 8, 16 and 32 bit boundaries. The inputs are chosen to force carries and borrows across every boundary. Condition patterns set only the fields a mode should read, or only the fields it should ignore. A run of pseudo-random operations mixes all modes, selectors and opcodes.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [1:0] {
        EW_64 = 2'd0,
        EW_32 = 2'd1,
        EW_16 = 2'd2,
        EW_8  = 2'd3
    } elem_w_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_fn_e;

    typedef struct packed {
        logic      legal;
        logic      arith;
        logic      invert_b;
        logic_fn_e lfn;
    } op_ctl_t;

    // log2 of the lane size in bytes for a given element width
    function automatic int unsigned lane_lg(elem_w_e w);
        case (w)
            EW_64:   return 3;
            EW_32:   return 2;
            EW_16:   return 1;
            default: return 0;
        endcase
    endfunction

    function automatic op_ctl_t decode_op(logic [2:0] raw);
        op_ctl_t c;
        c = '{legal: 1'b1, arith: 1'b0, invert_b: 1'b0, lfn: LG_AND};
        case (raw)
            OP_ADD: c.arith = 1'b1;
            OP_SUB: begin c.arith = 1'b1; c.invert_b = 1'b1; end
            OP_AND: c.lfn = LG_AND;
            OP_OR:  c.lfn = LG_OR;
            OP_XOR: c.lfn = LG_XOR;
            default: c.legal = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/simd_pred_mask.sv
module simd_pred_mask
    import simd_alu_pkg::*;
#(
    parameter int NB      = 8,
    parameter int FIELD_W = 4,
    localparam int SEL_W  = $clog2(FIELD_W)
) (
    input  logic [NB*FIELD_W-1:0] cond_fields,
    input  logic [SEL_W-1:0]      bit_sel,
    input  logic                  sel_avail,
    input  logic                  pred_en,
    input  elem_w_e               width,
    output logic [NB-1:0]         byte_en
);

    logic [SEL_W-1:0] eff_sel;
    logic [NB-1:0]    field_bit;
    int unsigned      lg;

    always_comb begin
        eff_sel = sel_avail ? bit_sel : '0;
        lg      = lane_lg(width);
    end

    generate
        for (genvar f = 0; f < NB; f++) begin : g_field
            logic [FIELD_W-1:0] fld;
            assign fld          = cond_fields[f*FIELD_W +: FIELD_W];
            assign field_bit[f] = fld[eff_sel];
        end

        for (genvar b = 0; b < NB; b++) begin : g_byte
            int unsigned owner;
            always_comb begin
                owner      = (b >> lg) << lg;
                byte_en[b] = pred_en ? field_bit[owner] : 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int NB = 8,
    localparam int DW = NB * 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  elem_w_e       width,
    input  op_ctl_t       ctl,
    output logic [DW-1:0] res
);

    logic [DW-1:0] arith_res;
    logic [DW-1:0] logic_res;

    // Byte-serial carry chain, cut at each lane start
    always_comb begin
        logic        carry;
        logic [8:0]  s;
        logic [7:0]  bb;
        int unsigned lsz;
        lsz   = 1 << lane_lg(width);
        carry = 1'b0;
        arith_res = '0;
        for (int i = 0; i < NB; i++) begin
            if ((i % lsz) == 0) carry = ctl.invert_b;
            bb = b[i*8 +: 8] ^ {8{ctl.invert_b}};
            s  = {1'b0, a[i*8 +: 8]} + {1'b0, bb} + {8'd0, carry};
            arith_res[i*8 +: 8] = s[7:0];
            carry = s[8];
        end
    end

    always_comb begin
        case (ctl.lfn)
            LG_OR:   logic_res = a | b;
            LG_XOR:  logic_res = a ^ b;
            default: logic_res = a & b;
        endcase
    end

    always_comb begin
        if (!ctl.legal)     res = '0;
        else if (ctl.arith) res = arith_res;
        else                res = logic_res;
    end

endmodule

// File: rtl/simd_pred_alu.sv
module simd_pred_alu
    import simd_alu_pkg::*;
#(
    parameter int HALF_W  = 32,
    parameter int FIELD_W = 4,
    localparam int DW     = 2 * HALF_W,
    localparam int NB     = DW / 8,
    localparam int SEL_W  = $clog2(FIELD_W)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [HALF_W-1:0]     a_hi,
    input  logic [HALF_W-1:0]     a_lo,
    input  logic [HALF_W-1:0]     b_hi,
    input  logic [HALF_W-1:0]     b_lo,
    input  logic [1:0]            width,
    input  logic [2:0]            op,
    input  logic [NB*FIELD_W-1:0] cond_fields,
    input  logic [SEL_W-1:0]      bit_sel,
    input  logic                  sel_avail,
    input  logic                  pred_en,
    input  logic [DW-1:0]         old_dst,
    output logic                  out_valid,
    output logic [DW-1:0]         result,
    output logic [NB-1:0]         byte_en
);

    elem_w_e       ew;
    op_ctl_t       ctl;
    logic [DW-1:0] a_full, b_full, alu_res, merged;
    logic [NB-1:0] be_nxt;

    always_comb begin
        ew     = elem_w_e'(width);
        ctl    = decode_op(op);
        a_full = {a_hi, a_lo};
        b_full = {b_hi, b_lo};
    end

    simd_pred_mask #(.NB(NB), .FIELD_W(FIELD_W)) u_mask (
        .cond_fields (cond_fields),
        .bit_sel     (bit_sel),
        .sel_avail   (sel_avail),
        .pred_en     (pred_en),
        .width       (ew),
        .byte_en     (be_nxt)
    );

    simd_lane_alu #(.NB(NB)) u_alu (
        .a     (a_full),
        .b     (b_full),
        .width (ew),
        .ctl   (ctl),
        .res   (alu_res)
    );

    generate
        for (genvar g = 0; g < NB; g++) begin : g_merge
            assign merged[g*8 +: 8] = be_nxt[g] ? alu_res[g*8 +: 8] : old_dst[g*8 +: 8];

            // R8: a masked byte returns the old destination byte
            p_masked_keeps_old_r8: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> (byte_en[g] || result[g*8 +: 8] == $past(old_dst[g*8 +: 8])));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            byte_en   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= merged;
                byte_en <= be_nxt;
            end
        end
    end

    // R11: valid follows input valid one cycle later
    p_valid_latency_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    // R7: predication off enables every byte
    p_unpred_all_on_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pred_en) |=> (byte_en == '1));

    // R3: full width has one uniform predicate
    p_full_uniform_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && width == EW_64) |=> (byte_en == '0 || byte_en == '1));

    // R4: each 32-bit half has one uniform predicate
    p_half_uniform_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && width == EW_32) |=>
            ((byte_en[NB/2-1:0] == '0 || byte_en[NB/2-1:0] == '1) &&
             (byte_en[NB-1:NB/2] == '0 || byte_en[NB-1:NB/2] == '1)));

endmodule

// File: tb/simd_pred_alu_tb.sv
module simd_pred_alu_tb_top;

    typedef struct {
        logic [63:0] res;
        logic [7:0]  be;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] a_hi, a_lo, b_hi, b_lo;
    logic [1:0]  width;
    logic [2:0]  op;
    logic [31:0] cond_fields;
    logic [1:0]  bit_sel;
    logic        sel_avail, pred_en;
    logic [63:0] old_dst;
    logic        out_valid;
    logic [63:0] result;
    logic [7:0]  byte_en;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    simd_pred_alu dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
        .width(width), .op(op), .cond_fields(cond_fields),
        .bit_sel(bit_sel), .sel_avail(sel_avail), .pred_en(pred_en),
        .old_dst(old_dst), .out_valid(out_valid), .result(result),
        .byte_en(byte_en)
    );

    function automatic void model(
        input logic [63:0] a, input logic [63:0] b, input logic [63:0] old,
        input logic [1:0] w, input logic [2:0] o, input logic [31:0] cf,
        input logic [1:0] sel, input logic avail, input logic pen,
        output logic [63:0] res, output logic [7:0] be);
        int          lsz, lw;
        logic [63:0] m, al, bl, r, full;
        logic        p;
        lsz  = 8 >> w;
        lw   = lsz * 8;
        m    = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
        full = '0;
        be   = '0;
        for (int k = 0; k < 8 / lsz; k++) begin
            al = (a >> (k * lw)) & m;
            bl = (b >> (k * lw)) & m;
            case (o)
                3'd0: r = al + bl;
                3'd1: r = al - bl;
                3'd2: r = al & bl;
                3'd3: r = al | bl;
                3'd4: r = al ^ bl;
                default: r = '0;
            endcase
            full = full | ((r & m) << (k * lw));
            p = pen ? cf[(k * lsz) * 4 + (avail ? int'(sel) : 0)] : 1'b1;
            for (int j = 0; j < lsz; j++) be[k * lsz + j] = p;
        end
        for (int i = 0; i < 8; i++)
            res[i*8 +: 8] = be[i] ? full[i*8 +: 8] : old[i*8 +: 8];
    endfunction

    task automatic send(input logic [31:0] ah, input logic [31:0] alo,
                        input logic [31:0] bh, input logic [31:0] blo,
                        input logic [1:0] w, input logic [2:0] o,
                        input logic [31:0] cf, input logic [1:0] sel,
                        input logic avail, input logic pen,
                        input logic [63:0] old, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; a_hi = ah; a_lo = alo; b_hi = bh; b_lo = blo;
        width = w; op = o; cond_fields = cf; bit_sel = sel;
        sel_avail = avail; pred_en = pen; old_dst = old;
        model({ah, alo}, {bh, blo}, old, w, o, cf, sel, avail, pen, e.res, e.be);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 idle out_valid actual=%b expected=0", out_valid);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected out_valid actual=1 expected=0");
            end else begin
                e = sb.pop_front();
                if (result !== e.res || byte_en !== e.be) begin
                    errors++;
                    $display("FAIL %s result=%h be=%h expected result=%h be=%h",
                             e.tag, result, byte_en, e.res, e.be);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] s;
        rst = 1'b1; in_valid = 1'b0;
        a_hi = '0; a_lo = '0; b_hi = '0; b_lo = '0; width = '0; op = '0;
        cond_fields = '0; bit_sel = '0; sel_avail = 1'b0; pred_en = 1'b0; old_dst = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 64'd0 || byte_en !== 8'd0) begin
            errors++;
            $display("FAIL R11 reset state actual=%b/%h/%h expected=0/0/0",
                     out_valid, result, byte_en);
        end
        rst = 1'b0;

        // R1: carry from low half into high half in full width
        send(32'h0, 32'hFFFF_FFFF, 32'h0, 32'h1, 2'd0, 3'd0, 32'h0, 2'd0, 1'b0, 1'b0, 64'h0, "R1");
        send(32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_0001, 32'h0000_0010, 2'd0, 3'd0, 32'h0, 2'd0, 1'b0, 1'b0, 64'h0, "R1");
        // R9: carries stop at lane boundaries
        send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0101_0101, 32'h0101_0101, 2'd3, 3'd0, 32'h0, 2'd0, 1'b0, 1'b0, 64'h0, "R9");
        send(32'h0, 32'h0, 32'h0001_0001, 32'h0001_0001, 2'd2, 3'd1, 32'h0, 2'd0, 1'b0, 1'b0, 64'h0, "R9");
        send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 32'h1, 2'd1, 3'd0, 32'h0, 2'd0, 1'b0, 1'b0, 64'h0, "R9");
        send(32'h0, 32'h0, 32'h0, 32'h1, 2'd0, 3'd1, 32'h0, 2'd0, 1'b0, 1'b0, 64'h0, "R9");
        // R10: logic ops and illegal opcode
        send(32'hF0F0_AAAA, 32'h1234_5678, 32'hFF00_5555, 32'h0F0F_FFFF, 2'd0, 3'd2, 32'h0, 2'd0, 1'b0, 1'b0, 64'h0, "R10");
        send(32'hF0F0_AAAA, 32'h1234_5678, 32'hFF00_5555, 32'h0F0F_FFFF, 2'd3, 3'd3, 32'h0, 2'd0, 1'b0, 1'b0, 64'h0, "R10");
        send(32'hF0F0_AAAA, 32'h1234_5678, 32'hFF00_5555, 32'h0F0F_FFFF, 2'd1, 3'd4, 32'h0, 2'd0, 1'b0, 1'b0, 64'h0, "R10");
        send(32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h1, 32'h2, 2'd2, 3'd6, 32'h0, 2'd0, 1'b0, 1'b0, 64'h0, "R10");
        idle_check();
        // R7: predication off ignores condition fields
        send(32'h1, 32'h2, 32'h3, 32'h4, 2'd3, 3'd0, 32'h0000_0000, 2'd1, 1'b1, 1'b0, 64'h5555_5555_5555_5555, "R7");
        // R6: byte lanes, selector bit 2
        send(32'h1111_1111, 32'h2222_2222, 32'h0101_0101, 32'h0101_0101, 2'd3, 3'd0, 32'h4044_0404, 2'd2, 1'b1, 1'b1, 64'hA5A5_A5A5_A5A5_A5A5, "R6");
        // R2: no selector, bit 0 used
        send(32'h1111_1111, 32'h2222_2222, 32'h0101_0101, 32'h0101_0101, 2'd3, 3'd0, 32'h1415_4140, 2'd2, 1'b0, 1'b1, 64'hA5A5_A5A5_A5A5_A5A5, "R2");
        send(32'h1111_1111, 32'h2222_2222, 32'h0, 32'h0, 2'd3, 3'd3, 32'h8000_0808, 2'd3, 1'b1, 1'b1, 64'h0, "R2");
        // R5: odd fields ignored, even fields used
        send(32'h0, 32'h0, 32'h1, 32'h1, 2'd2, 3'd0, 32'hF0F0_F0F0, 2'd0, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, "R5");
        send(32'h0, 32'h0, 32'h1, 32'h1, 2'd2, 3'd0, 32'h000F_000F, 2'd1, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, "R5");
        // R4: only field 4 enables the upper half
        send(32'h10, 32'h20, 32'h1, 32'h2, 2'd1, 3'd0, 32'hFFF1_FFF0, 2'd0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        send(32'h10, 32'h20, 32'h1, 32'h2, 2'd1, 3'd1, 32'h0000_0001, 2'd0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        // R3: only field 0 counts in full width
        send(32'h7, 32'h8, 32'h1, 32'h1, 2'd0, 3'd0, 32'hFFFF_FFF0, 2'd0, 1'b1, 1'b1, 64'h0BAD_0BAD_0BAD_0BAD, "R3");
        send(32'h7, 32'h8, 32'h1, 32'h1, 2'd0, 3'd0, 32'h0000_0002, 2'd1, 1'b1, 1'b1, 64'h0BAD_0BAD_0BAD_0BAD, "R3");
        // R8: masked bytes keep distinct old values
        send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 3'd2, 32'h0101_0101, 2'd0, 1'b1, 1'b1, 64'h0011_2233_4455_6677, "R8");
        idle_check();

        // mixed pseudo-random operations (R1..R11 together)
        s = 32'h1ACE_B00C;
        for (int n = 0; n < 48; n++) begin
            logic [31:0] v[5];
            logic [63:0] od;
            for (int q = 0; q < 5; q++) begin
                s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
                v[q] = s;
            end
            od = {v[4], v[3] ^ v[0]};
            send(v[0], v[1], v[2], v[3], v[4][1:0], 3'(v[4][4:2] % 6), v[1] ^ v[2],
                 v[4][6:5], v[4][7], v[4][8], od, "R9/R10 mixed");
        end

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R11 pending results actual=%0d expected=0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule